// File: doc/BRIEF.md
# Polled Word Crossbar for Serial Ports and Host

This block moves data words among nine endpoints: eight serial-port word interfaces (a pair for each of four signal processors) and one host endpoint. Each serial port has its own routing entry. The entry names the endpoint that receives every word arriving on that port. The target can be another serial port or the host. A routing entry can also discard the port's traffic.

A scan pointer visits one receive interface per clock, in a fixed circular order. When the visited port offers a word, the block checks the target. If the target can take the word, the word is acknowledged and moved. If not, the word stays where it is and is offered again on a later visit.

Every transmit side has a single holding register. Words for the host collect in a small first-in first-out buffer that the host drains. The host can also rewrite any routing entry and inject words directly into any port's transmit holding register.

Top module: `sport_xbar`

## Requirements
- R1: After reset, every routing entry holds code 8 (host), so a word received on any port with no prior configuration is delivered to the host buffer.
- R2: At most one rx_ready bit is high in any cycle, and only for a port whose rx_valid is high. The scan visits ports in ascending index order and wraps from 7 to 0. When all eight ports hold a word for the host, the eight words are accepted in eight consecutive cycles, in ascending circular port order.
- R3: A routing code from 0 to 7 that differs from the source index sends the word unchanged to that port's transmit side. A write of cfg_dest to entry cfg_port (cfg_we high) governs the words accepted from the next cycle on.
- R4: A routing code equal to the source port's own index, or a code from 9 to 15, makes the port a sink. Its words are acknowledged and appear at no transmit side and not in the host buffer.
- R5: Words routed with code 8 are presented on host_data and host_valid in arrival order. host_pop removes the word shown.
- R6: The host buffer holds 16 words. While it is full, a port routed to the host is not acknowledged and keeps its word. The word is accepted once the host pops an entry.
- R7: A transmit holding register keeps tx_valid high with stable tx_data until tx_ready is seen. While it is occupied, a source routed to that port is not acknowledged, and it is accepted on a later visit after the register empties.
- R8: inj_ready is high exactly when the transmit holding register of inj_port is empty. An accepted injection shows on that port's transmit side in the next cycle. When a routed word and an injection target the same port in the same cycle, the injection is taken and the routed word waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 8 | Per-port receive word available |
| rx_data | input | 128 | Per-port receive word, port p in bits [16p+15:16p] |
| rx_ready | output | 8 | Per-port acknowledge; word taken at this edge |
| tx_valid | output | 8 | Per-port transmit word held |
| tx_data | output | 128 | Per-port transmit word, port p in bits [16p+15:16p] |
| tx_ready | input | 8 | Per-port transmit side consumes the held word |
| cfg_we | input | 1 | Write routing entry |
| cfg_port | input | 3 | Routing entry index |
| cfg_dest | input | 4 | New routing code: 0-7 port, 8 host, else sink |
| inj_valid | input | 1 | Host word offered for injection |
| inj_port | input | 3 | Target port of the injection |
| inj_data | input | 16 | Injected word |
| inj_ready | output | 1 | Target holding register is empty |
| host_valid | output | 1 | Host buffer not empty |
| host_data | output | 16 | Oldest word in the host buffer |
| host_pop | input | 1 | Remove the oldest host word |

## Verification
A corrupted routing entry sends a word to the wrong tx lane, to the host buffer, or nowhere. This shows at the ports in the cycle right after that port's acknowledge. A scan pointer that skips or repeats a port breaks the eight-cycle, circular acceptance order when all ports compete for the host. It can also leave a port without an acknowledge for longer than one full pass. A wrong occupancy state in a holding register or in the host buffer shows up in one of three ways: an overwritten tx word, a lost or duplicated host word, or an acknowledge given while the target is full. Each of these is visible within one or two cycles of the stall condition.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [1:0] {
    RK_DROP = 2'd0,
    RK_PORT = 2'd1,
    RK_HOST = 2'd2
  } route_kind_e;
endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs #(
  parameter int NPORT = 8,
  parameter int PW    = 3,
  parameter int CW    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [PW-1:0]         wr_idx,
  input  logic [CW-1:0]         wr_code,
  output logic [NPORT*CW-1:0]   codes
);
  for (genvar i = 0; i < NPORT; i++) begin : g_entry
    logic [CW-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst)                              code_q <= CW'(NPORT);
      else if (we && wr_idx == PW'(i))      code_q <= wr_code;
    end
    assign codes[i*CW +: CW] = code_q;

    assert_cfg_write_R3: assert property (@(posedge clk) disable iff (rst)
      (we && wr_idx == PW'(i)) |=> (code_q == $past(wr_code)));
  end
endmodule

// File: rtl/xbar_scan.sv
module xbar_scan #(
  parameter int NPORT = 8,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NPORT - 1);

  always_ff @(posedge clk) begin
    if (rst)              ptr <= '0;
    else if (ptr == LAST) ptr <= '0;
    else                  ptr <= ptr + 1'b1;
  end

  assert_scan_step_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));
endmodule

// File: rtl/xbar_tx_slot.sv
module xbar_tx_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) data <= load_data;
  end

  assert_slot_no_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid);
  assert_slot_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && !take) |=> (valid && $stable(data)));
endmodule

// File: rtl/xbar_host_fifo.sv
module xbar_host_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full     = (count == (AW+1)'(DEPTH));
  assign rd_valid = (count != '0);
  assign rd_data  = mem[rd_ptr];

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    pop |-> rd_valid);
endmodule

// File: rtl/sport_xbar.sv
module sport_xbar
  import xbar_pkg::*;
#(
  parameter int NPORT  = 8,
  parameter int W      = 16,
  parameter int HDEPTH = 16,
  localparam int PW    = $clog2(NPORT),
  localparam int CW    = $clog2(NPORT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORT-1:0]   rx_valid,
  input  logic [NPORT*W-1:0] rx_data,
  output logic [NPORT-1:0]   rx_ready,
  output logic [NPORT-1:0]   tx_valid,
  output logic [NPORT*W-1:0] tx_data,
  input  logic [NPORT-1:0]   tx_ready,
  input  logic               cfg_we,
  input  logic [PW-1:0]      cfg_port,
  input  logic [CW-1:0]      cfg_dest,
  input  logic               inj_valid,
  input  logic [PW-1:0]      inj_port,
  input  logic [W-1:0]       inj_data,
  output logic               inj_ready,
  output logic               host_valid,
  output logic [W-1:0]       host_data,
  input  logic               host_pop
);
  logic [NPORT*CW-1:0] codes;
  logic [PW-1:0]       scan;
  logic [CW-1:0]       cur_code;
  logic [PW-1:0]       dst_idx;
  logic [W-1:0]        cur_word;
  route_kind_e         kind;
  logic                fwd_ok, take, inj_go, fifo_full;

  xbar_cfg_regs #(.NPORT(NPORT), .PW(PW), .CW(CW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wr_idx(cfg_port),
    .wr_code(cfg_dest), .codes(codes)
  );

  xbar_scan #(.NPORT(NPORT), .PW(PW)) u_scan (
    .clk(clk), .rst(rst), .ptr(scan)
  );

  assign cur_code = codes[scan*CW +: CW];
  assign cur_word = rx_data[scan*W +: W];
  assign dst_idx  = cur_code[PW-1:0];

  always_comb begin
    if (cur_code == CW'(scan) || cur_code > CW'(NPORT)) kind = RK_DROP;
    else if (cur_code == CW'(NPORT))                     kind = RK_HOST;
    else                                                 kind = RK_PORT;
  end

  assign inj_ready = !tx_valid[inj_port];
  assign inj_go    = inj_valid && inj_ready;

  always_comb begin
    case (kind)
      RK_DROP: fwd_ok = 1'b1;
      RK_HOST: fwd_ok = !fifo_full;
      RK_PORT: fwd_ok = !tx_valid[dst_idx] && !(inj_go && inj_port == dst_idx);
      default: fwd_ok = 1'b0;
    endcase
  end

  assign take     = rx_valid[scan] && fwd_ok;
  assign rx_ready = take ? (NPORT'(1) << scan) : '0;

  for (genvar i = 0; i < NPORT; i++) begin : g_lane
    logic         inj_here, fwd_here;
    logic [W-1:0] ld_word;
    assign inj_here = inj_go && inj_port == PW'(i);
    assign fwd_here = take && kind == RK_PORT && dst_idx == PW'(i);
    assign ld_word  = inj_here ? inj_data : cur_word;

    xbar_tx_slot #(.W(W)) u_slot (
      .clk(clk), .rst(rst), .load(inj_here || fwd_here), .load_data(ld_word),
      .take(tx_ready[i]), .valid(tx_valid[i]), .data(tx_data[i*W +: W])
    );

    assert_inj_lands_R8: assert property (@(posedge clk) disable iff (rst)
      (inj_valid && inj_ready && inj_port == PW'(i)) |=>
        (tx_valid[i] && tx_data[i*W +: W] == $past(inj_data)));
  end

  xbar_host_fifo #(.W(W), .DEPTH(HDEPTH)) u_hfifo (
    .clk(clk), .rst(rst), .push(take && kind == RK_HOST), .push_data(cur_word),
    .full(fifo_full), .pop(host_pop && host_valid),
    .rd_valid(host_valid), .rd_data(host_data)
  );

  assert_single_ack_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rx_ready));
  assert_ack_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_ready & ~rx_valid) == '0);
endmodule

// File: tb/tb_sport_xbar.sv
`timescale 1ns/1ps
module tb_sport_xbar;
  localparam int NP = 8;
  localparam int W  = 16;

  logic clk = 0, rst = 1;
  logic [NP-1:0]   rx_valid = '0, rx_ready, tx_valid, tx_ready = '0;
  logic [NP*W-1:0] rx_data = '0, tx_data;
  logic cfg_we = 0; logic [2:0] cfg_port = '0; logic [3:0] cfg_dest = '0;
  logic inj_valid = 0; logic [2:0] inj_port = '0; logic [W-1:0] inj_data = '0;
  logic inj_ready, host_valid, host_pop = 0; logic [W-1:0] host_data;

  int checks = 0, fails = 0; bit done = 0;

  always #4 clk = ~clk;

  sport_xbar dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_dest(cfg_dest),
    .inj_valid(inj_valid), .inj_port(inj_port), .inj_data(inj_data), .inj_ready(inj_ready),
    .host_valid(host_valid), .host_data(host_data), .host_pop(host_pop)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  // R2 monitor: single acknowledge, only for a valid port
  always @(negedge clk) begin
    #1;
    if (!rst && ($countones(rx_ready) > 1 || (rx_ready & ~rx_valid) != '0)) begin
      fails++;
      $display("FAIL R2 ack act=%h exp=onehot within %h", rx_ready, rx_valid);
    end
  end

  task automatic set_route(int p, int code);
    cfg_we = 1; cfg_port = 3'(p); cfg_dest = 4'(code);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic present(int p, logic [W-1:0] d);
    rx_valid[p] = 1; rx_data[p*W +: W] = d;
  endtask

  task automatic wait_ack(int p, int limit, output bit got);
    got = 0;
    for (int n = 0; n < limit && !got; n++) begin
      #1;
      if (rx_ready[p]) begin @(negedge clk); rx_valid[p] = 0; got = 1; end
      else @(negedge clk);
    end
  endtask

  task automatic send(int p, logic [W-1:0] d, string req);
    bit got;
    present(p, d); wait_ack(p, 40, got);
    chk(got, req, {31'd0, got}, 32'd1);
  endtask

  task automatic pop_check(logic [W-1:0] exp, string req);
    #1; chk(host_valid && host_data == exp, req, {15'd0, host_valid, host_data}, {16'd1, exp});
    host_pop = 1; @(negedge clk); host_pop = 0;
  endtask

  task automatic take_tx(int p, logic [W-1:0] exp, string req);
    #1; chk(tx_valid[p] && tx_data[p*W +: W] == exp, req,
            {15'd0, tx_valid[p], tx_data[p*W +: W]}, {16'd1, exp});
    tx_ready[p] = 1; @(negedge clk); tx_ready[p] = 0;
  endtask

  task automatic quiet(string req);
    #1; chk(tx_valid == '0 && !host_valid, req, {23'd0, host_valid, tx_valid}, 32'd0);
  endtask

  task automatic t_reset;
    #1; chk(tx_valid == '0 && !host_valid && rx_ready == '0 && inj_ready, "R1 reset",
            {22'd0, inj_ready, host_valid, tx_valid}, 32'h200);
  endtask

  task automatic t_default_host; // R1
    send(3, 16'h1303, "R1 ack");
    pop_check(16'h1303, "R1 host delivery");
    quiet("R1 nothing left");
  endtask

  task automatic t_port_route; // R3
    set_route(0, 5);
    send(0, 16'hA5A5, "R3 ack");
    #1; chk(tx_valid == 8'h20 && !host_valid, "R3 only lane 5", {24'd0, tx_valid}, 32'h20);
    take_tx(5, 16'hA5A5, "R3 word");
    set_route(0, 8);
  endtask

  task automatic t_sink; // R4
    set_route(2, 2);
    send(2, 16'h2222, "R4 self ack");
    @(negedge clk); quiet("R4 self dropped");
    set_route(2, 12);
    send(2, 16'h2C2C, "R4 reserved ack");
    @(negedge clk); quiet("R4 reserved dropped");
    set_route(2, 8);
  endtask

  task automatic t_scan_order; // R2 and R5
    logic [NP-1:0] acked = '0; int cyc = 0; logic [W-1:0] prev;
    for (int p = 0; p < NP; p++) present(p, 16'h2200 + 16'(p));
    while (acked != '1 && cyc < 40) begin
      logic [NP-1:0] a;
      #1; a = rx_ready; cyc++;
      @(negedge clk);
      acked |= a; rx_valid &= ~a;
    end
    chk(cyc == NP, "R2 eight cycles", cyc, NP);
    #1; prev = host_data;
    host_pop = 1; @(negedge clk); host_pop = 0;
    for (int k = 1; k < NP; k++) begin
      logic [W-1:0] e;
      e = 16'h2200 + 16'((prev[2:0] + 1) % NP);
      pop_check(e, "R2 circular order");
      prev = e;
    end
    quiet("R5 drained");
  endtask

  task automatic t_full; // R6 and R5
    bit got;
    for (int k = 0; k < 16; k++) send(7, 16'h6000 + 16'(k), "R6 fill");
    present(7, 16'h6010); wait_ack(7, 20, got);
    chk(!got, "R6 stalled when full", {31'd0, got}, 32'd0);
    pop_check(16'h6000, "R5 first out");
    wait_ack(7, 20, got);
    chk(got, "R6 accepted after pop", {31'd0, got}, 32'd1);
    for (int k = 1; k <= 16; k++) pop_check(16'h6000 + 16'(k), "R5 order");
    quiet("R6 empty");
  endtask

  task automatic t_busy_dest; // R7
    bit got;
    set_route(1, 6);
    send(1, 16'hB001, "R7 first");
    present(1, 16'hB002); wait_ack(1, 20, got);
    chk(!got, "R7 blocked by busy lane", {31'd0, got}, 32'd0);
    take_tx(6, 16'hB001, "R7 held word stable");
    wait_ack(1, 20, got);
    chk(got, "R7 retried", {31'd0, got}, 32'd1);
    take_tx(6, 16'hB002, "R7 second word");
    set_route(1, 8);
  endtask

  task automatic t_inject; // R8
    bit got;
    inj_valid = 1; inj_port = 3'd4; inj_data = 16'hC4C4;
    #1; chk(inj_ready, "R8 ready when empty", {31'd0, inj_ready}, 32'd1);
    @(negedge clk); inj_valid = 0;
    #1; chk(!inj_ready, "R8 not ready when held", {31'd0, inj_ready}, 32'd0);
    take_tx(4, 16'hC4C4, "R8 injected word");
    set_route(0, 4);
    present(0, 16'hD0D0);
    inj_valid = 1; inj_data = 16'hE4E4;
    #1; chk(inj_ready, "R8 ready at contention", {31'd0, inj_ready}, 32'd1);
    @(negedge clk); inj_valid = 0;
    take_tx(4, 16'hE4E4, "R8 injection wins");
    wait_ack(0, 20, got);
    chk(got, "R8 routed word follows", {31'd0, got}, 32'd1);
    take_tx(4, 16'hD0D0, "R8 routed word");
    set_route(0, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_default_host();
    t_port_route();
    t_sink();
    t_scan_order();
    t_full();
    t_busy_dest();
    t_inject();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule